// File: doc/BRIEF.md
# Reloadable Watchdog Counter with Selectable Time Unit

This block is a watchdog built around a 16-bit down-counter and programmed through four byte-wide configuration registers. Time comes from an external one-second tick. In seconds mode each tick takes one off the count. In minutes mode an internal prescaler collects a fixed number of ticks (sixty by default) for each decrement. A timeout value of zero holds the counter idle.

Software does not reload the counter through a dedicated kick register. Activity seen on selected peripherals reloads it instead: an infrared-receiver data write, mouse or keyboard activity, or a game-port read strobe. Each source has its own enable bit. The reload lands a fixed number of clock cycles after the event. When the count runs out, or a force is requested, a sticky timeout flag is set. Depending on the configuration, the block can also emit a keyboard-reset pulse, a power-OK pulse, or both. The flag stays set until the control register is written with zero.

Top module: `wdt_reload_timer`

## Requirements
- R1: Register layout. Offset 0x71 is control: bit7 enables the infrared source, bit6 mouse, bit5 keyboard, bit4 game port, bit1 is a write-only force that reads 0, and bit0 is the timeout flag (read-only). Offset 0x72 is configuration: bit7 set selects seconds and clear selects minutes, bit6 enables the keyboard-reset pulse, bit4 enables the power-OK pulse, and all other bits read 0. Offsets 0x73 and 0x74 hold the low and high bytes of the timeout value. Any other offset reads 0. Every register resets to 0.
- R2: In seconds mode, after the timeout value N (N > 0) is written, the flag is set by the Nth tick and not before.
- R3: In minutes mode, the flag is set by tick number TICKS_PER_MIN*N after the value write and not before.
- R4: With a timeout value of zero, ticks never set the flag.
- R5: A one-cycle event on an enabled source restores the count to the full timeout value RELOAD_DLY cycles after the event. An event on a disabled source has no effect.
- R6: A tick that arrives inside the reload delay window still acts on the old count.
- R7: A control write with bit1 set, or a pulse on force_req, sets the flag on the next clock and stops the counter at zero.
- R8: The flag stays set through ticks and through nonzero control writes. A control write of 0x00 clears it.
- R9: On each expiry the keyboard-reset output pulses high for exactly RST_PULSE cycles if configuration bit6 was set, and the power-OK output does the same if bit4 was set. An output whose enable bit is clear stays low.
- R10: A write to either timeout byte loads the counter from the full 16-bit value and clears the minutes prescaler.
- R11: After an expiry the counter stays at zero, so further ticks produce no second pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| tick | input | 1 | One-second time base pulse |
| ev_ir | input | 1 | Infrared receiver data write event |
| ev_mouse | input | 1 | Mouse activity event |
| ev_kbd | input | 1 | Keyboard activity event |
| ev_game | input | 1 | Game-port read strobe |
| force_req | input | 1 | Force an immediate timeout |
| kbd_rst | output | 1 | Keyboard-reset pulse |
| pwrok_pulse | output | 1 | Power-OK pulse |
| expired | output | 1 | Sticky timeout flag |

## Verification
The bench sweeps the timeout value in both time units and checks that the flag rises on exactly the last expected tick. An off-by-one decrement, or a prescaler that wraps at the wrong count, would shift that edge by one tick or by a whole minute.

For each of the four sources, the bench fires the event with its enable bit set and then with it clear. A wrongly mapped enable bit would reload when it should not, or miss a reload it should make. A tick placed inside the reload delay window must still expire the old count, which catches a reload applied with no delay. Further checks cover a stale prescaler after a value rewrite, a flag that a nonzero control write clears, and a second reset pulse from a counter that keeps running past zero.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] ADDR_CTRL = 8'h71;
  localparam logic [7:0] ADDR_CFG  = 8'h72;
  localparam logic [7:0] ADDR_VLO  = 8'h73;
  localparam logic [7:0] ADDR_VHI  = 8'h74;

  // Control byte fields
  localparam int CTRL_SRC_LSB = 4;  // [7:4] = {ir, mouse, kbd, game}
  localparam int CTRL_FORCE   = 1;
  localparam int CTRL_FLAG    = 0;

  // Configuration byte fields
  localparam int CFG_SECONDS  = 7;
  localparam int CFG_KBD_EN   = 6;
  localparam int CFG_PWR_EN   = 4;

  // Is a decrement due on this tick, given the unit and the prescaler state?
  function automatic logic wdt_dec_due(input logic unit_sec, input int pre, input int lim);
    return unit_sec || (pre == lim - 1);
  endfunction

  // Next prescaler value on a tick in minutes mode
  function automatic int wdt_pre_next(input int pre, input int lim);
    return (pre == lim - 1) ? 0 : pre + 1;
  endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [7:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          expire_evt,
  output logic [3:0]    src_en,
  output logic          unit_sec,
  output logic          kbd_en,
  output logic          pwr_en,
  output logic [CW-1:0] value,
  output logic          val_load,
  output logic [CW-1:0] val_new,
  output logic          force_wr,
  output logic          status
);
  logic ctrl_wr, ctrl_clr;
  assign ctrl_wr  = wr && (addr == ADDR_CTRL);
  assign ctrl_clr = ctrl_wr && (wdata == '0);
  assign force_wr = ctrl_wr && wdata[CTRL_FORCE];
  assign val_load = wr && ((addr == ADDR_VLO) || (addr == ADDR_VHI));

  always_comb begin
    val_new = value;
    if (wr && addr == ADDR_VLO) val_new[7:0]  = wdata;
    if (wr && addr == ADDR_VHI) val_new[15:8] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_en <= '0; unit_sec <= 1'b0; kbd_en <= 1'b0; pwr_en <= 1'b0;
      value <= '0; status <= 1'b0;
    end else begin
      if (ctrl_wr) src_en <= wdata[CTRL_SRC_LSB +: 4];
      if (wr && addr == ADDR_CFG) begin
        unit_sec <= wdata[CFG_SECONDS];
        kbd_en   <= wdata[CFG_KBD_EN];
        pwr_en   <= wdata[CFG_PWR_EN];
      end
      if (val_load) value <= val_new;
      if (expire_evt)    status <= 1'b1;
      else if (ctrl_clr) status <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_CTRL: begin
        rdata[CTRL_SRC_LSB +: 4] = src_en;
        rdata[CTRL_FLAG]         = status;
      end
      ADDR_CFG: begin
        rdata[CFG_SECONDS] = unit_sec;
        rdata[CFG_KBD_EN]  = kbd_en;
        rdata[CFG_PWR_EN]  = pwr_en;
      end
      ADDR_VLO: rdata = value[7:0];
      ADDR_VHI: rdata = value[15:8];
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_reload_delay.sv
module wdt_reload_delay #(
  parameter int NSRC = 4,
  parameter int DLY  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] ev,
  input  logic [NSRC-1:0] en,
  input  logic            cancel,
  output logic            reload_stb,
  output logic            busy
);
  localparam int DCW = $clog2(DLY + 1);
  logic [DCW-1:0] dcnt;
  logic           fire;

  assign fire       = |(ev & en);
  assign reload_stb = (dcnt == DCW'(1));
  assign busy       = (dcnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           dcnt <= '0;
    else if (cancel)      dcnt <= '0;
    else if (fire)        dcnt <= DCW'(DLY);
    else if (dcnt != '0)  dcnt <= dcnt - DCW'(1);
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int CW  = 16,
  parameter int TPM = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          unit_sec,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          reload,
  input  logic [CW-1:0] reload_val,
  input  logic          force_evt,
  output logic          expire_evt
);
  localparam int PW = (TPM > 1) ? $clog2(TPM) : 1;
  logic [CW-1:0] cnt;
  logic [PW-1:0] pre;
  logic          due, tick_exp;

  assign due        = wdt_dec_due(unit_sec, int'(pre), TPM);
  assign tick_exp   = tick && (cnt == CW'(1)) && due && !load && !reload;
  assign expire_evt = force_evt || tick_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; pre <= '0;
    end else if (load) begin
      cnt <= load_val; pre <= '0;
    end else if (force_evt) begin
      cnt <= '0; pre <= '0;
    end else if (reload) begin
      cnt <= reload_val; pre <= '0;
    end else if (tick && cnt != '0) begin
      if (due) cnt <= cnt - CW'(1);
      pre <= unit_sec ? '0 : PW'(wdt_pre_next(int'(pre), TPM));
    end
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic kbd_en,
  input  logic pwr_en,
  output logic kbd_rst,
  output logic pwrok,
  output logic active
);
  localparam int PCW = $clog2(LEN + 1);
  logic [PCW-1:0] pcnt;
  logic           kbd_l, pwr_l;

  assign active  = (pcnt != '0);
  assign kbd_rst = active && kbd_l;
  assign pwrok   = active && pwr_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0; kbd_l <= 1'b0; pwr_l <= 1'b0;
    end else if (fire) begin
      pcnt <= PCW'(LEN); kbd_l <= kbd_en; pwr_l <= pwr_en;
    end else if (pcnt != '0) begin
      pcnt <= pcnt - PCW'(1);
    end
  end
endmodule

// File: rtl/wdt_reload_timer.sv
module wdt_reload_timer #(
  parameter int TICKS_PER_MIN = 60,
  parameter int RELOAD_DLY    = 4,
  parameter int RST_PULSE     = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       tick,
  input  logic       ev_ir,
  input  logic       ev_mouse,
  input  logic       ev_kbd,
  input  logic       ev_game,
  input  logic       force_req,
  output logic       kbd_rst,
  output logic       pwrok_pulse,
  output logic       expired
);
  localparam int CW = 16;

  logic [3:0]    src_en;
  logic          unit_sec, kbd_en, pwr_en;
  logic [CW-1:0] value_q, val_new;
  logic          val_load, force_wr, force_evt;
  logic          expire_evt, reload_stb, dly_busy, pulse_active;

  assign force_evt = force_wr || force_req;

  wdt_regs #(.DW(8), .CW(CW)) u_regs (
    .clk, .rst_n, .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .expire_evt, .src_en, .unit_sec, .kbd_en, .pwr_en, .value(value_q),
    .val_load, .val_new, .force_wr, .status(expired)
  );

  wdt_reload_delay #(.NSRC(4), .DLY(RELOAD_DLY)) u_dly (
    .clk, .rst_n, .ev({ev_ir, ev_mouse, ev_kbd, ev_game}), .en(src_en),
    .cancel(val_load), .reload_stb, .busy(dly_busy)
  );

  wdt_counter #(.CW(CW), .TPM(TICKS_PER_MIN)) u_cnt (
    .clk, .rst_n, .tick, .unit_sec, .load(val_load), .load_val(val_new),
    .reload(reload_stb), .reload_val(value_q), .force_evt, .expire_evt
  );

  wdt_pulse #(.LEN(RST_PULSE)) u_pulse (
    .clk, .rst_n, .fire(expire_evt), .kbd_en, .pwr_en,
    .kbd_rst, .pwrok(pwrok_pulse), .active(pulse_active)
  );
endmodule

// File: rtl/wdt_reload_timer_chk.sv
module wdt_reload_timer_chk #(
  parameter int RST_PULSE = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [7:0]  reg_addr,
  input logic [7:0]  reg_wdata,
  input logic        force_req,
  input logic        kbd_rst,
  input logic        expired,
  input logic        expire_evt,
  input logic        force_evt,
  input logic        reload_stb,
  input logic        dly_busy,
  input logic [15:0] value_q
);
  logic [7:0] hi_run;
  logic       clr_wr;
  assign clr_wr = reg_wr && (reg_addr == 8'h71) && (reg_wdata == 8'h00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_run <= '0;
    else if (kbd_rst) hi_run <= hi_run + 8'd1;
    else              hi_run <= '0;
  end

  assert_expiry_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> expired);
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !clr_wr) |=> expired);
  assert_idle_when_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (value_q == 16'd0 && !force_evt && !expired) |=> !expired);
  assert_force_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
    force_req |=> expired);
  assert_reload_waits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reload_stb |-> $past(dly_busy));
  assert_pulse_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_rst |-> (hi_run < 8'(RST_PULSE)));
  assert_pulse_from_expiry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kbd_rst) |-> $past(expire_evt));
endmodule

bind wdt_reload_timer wdt_reload_timer_chk #(.RST_PULSE(RST_PULSE)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .force_req(force_req), .kbd_rst(kbd_rst), .expired(expired), .expire_evt(expire_evt),
  .force_evt(force_evt), .reload_stb(reload_stb), .dly_busy(dly_busy), .value_q(value_q)
);

// File: tb/sim_wdt_reload_timer.sv
module sim_wdt_reload_timer;
  localparam int CLK_PERIOD = 10;
  localparam int TPM  = 60;
  localparam int DLY  = 4;
  localparam int PLEN = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = '0, reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic tick = 1'b0, ev_ir = 1'b0, ev_mouse = 1'b0, ev_kbd = 1'b0, ev_game = 1'b0;
  logic force_req = 1'b0;
  logic kbd_rst, pwrok_pulse, expired;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_reload_timer #(.TICKS_PER_MIN(TPM), .RELOAD_DLY(DLY), .RST_PULSE(PLEN)) u0 (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata, .tick,
    .ev_ir, .ev_mouse, .ev_kbd, .ev_game, .force_req, .kbd_rst, .pwrok_pulse, .expired
  );

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
      summary();
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  // src: 3=ir 2=mouse 1=kbd 0=game
  task automatic pulse_src(input int src);
    @(negedge clk);
    ev_ir = (src == 3); ev_mouse = (src == 2); ev_kbd = (src == 1); ev_game = (src == 0);
    @(negedge clk);
    ev_ir = 1'b0; ev_mouse = 1'b0; ev_kbd = 1'b0; ev_game = 1'b0;
  endtask

  task automatic setup(input logic [7:0] cfg, input logic [3:0] en, input logic [15:0] v);
    idle(PLEN + 2);
    wr(8'h71, 8'h00);
    wr(8'h72, cfg);
    wr(8'h71, {en, 4'b0000});
    wr(8'h73, v[7:0]);
    wr(8'h74, v[15:8]);
  endtask

  // Expect the flag to rise exactly on tick n
  task automatic expire_on(input string req, input int n);
    for (int i = 1; i < n; i++) do_tick();
    check({req, " before last tick"}, int'(expired), 0);
    do_tick();
    check({req, " on last tick"}, int'(expired), 1);
  endtask

  task automatic width(input bit use_kbd, output int w);
    w = 0;
    for (int i = 0; i < 3 * PLEN; i++) begin
      if (use_kbd ? kbd_rst : pwrok_pulse) w++;
      @(negedge clk);
    end
  endtask

  initial begin
    logic [7:0] d;
    int w;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state and layout
    check("R1 reset flag", int'(expired), 0);
    check("R1 reset kbd_rst", int'(kbd_rst), 0);
    check("R1 reset pwrok", int'(pwrok_pulse), 0);
    for (int a = 8'h71; a <= 8'h74; a++) begin
      rd(8'(a), d);
      check("R1 reset register", int'(d), 0);
    end
    wr(8'h72, 8'hFF); rd(8'h72, d); check("R1 cfg readback", int'(d), 8'hD0);
    wr(8'h71, 8'hF0); rd(8'h71, d); check("R1 ctrl readback", int'(d), 8'hF0);
    wr(8'h73, 8'h5A); rd(8'h73, d); check("R1 value low", int'(d), 8'h5A);
    wr(8'h74, 8'hA5); rd(8'h74, d); check("R1 value high", int'(d), 8'hA5);
    rd(8'h75, d); check("R1 unmapped offset", int'(d), 0);

    // R2 seconds sweep
    for (int v = 1; v <= 20; v++) begin
      setup(8'h80, 4'h0, 16'(v));
      expire_on("R2 seconds", v);
    end

    // R3 minutes sweep
    for (int v = 1; v <= 3; v++) begin
      setup(8'h00, 4'h0, 16'(v));
      expire_on("R3 minutes", TPM * v);
    end

    // R10 prescaler cleared on value rewrite
    setup(8'h00, 4'h0, 16'd1);
    for (int i = 0; i < 30; i++) do_tick();
    wr(8'h73, 8'h01);
    expire_on("R10 prescaler restart", TPM);

    // R4 zero value
    setup(8'h80, 4'hF, 16'd0);
    for (int i = 0; i < 100; i++) do_tick();
    pulse_src(0); idle(DLY + 2);
    for (int i = 0; i < 10; i++) do_tick();
    check("R4 zero never expires", int'(expired), 0);

    // R5 each source enabled and disabled
    for (int s = 0; s < 4; s++) begin
      for (int on = 0; on < 2; on++) begin
        setup(8'h80, on ? 4'(1 << s) : 4'(~(1 << s)), 16'd3);
        do_tick(); do_tick();
        pulse_src(s);
        idle(DLY + 2);
        if (on) expire_on("R5 enabled source reloads", 3);
        else begin
          do_tick();
          check("R5 disabled source ignored", int'(expired), 1);
        end
      end
    end

    // R6 tick inside delay window acts on old count
    setup(8'h80, 4'h1, 16'd2);
    do_tick();
    pulse_src(0);
    do_tick();
    check("R6 tick during reload delay", int'(expired), 1);

    // R9 keyboard reset pulse only
    setup(8'hC0, 4'h0, 16'd2);
    expire_on("R9 kbd expiry", 2);
    w = 0;
    for (int i = 0; i < 3 * PLEN; i++) begin
      if (kbd_rst) w++;
      check("R9 pwrok disabled stays low", int'(pwrok_pulse), 0);
      @(negedge clk);
    end
    check("R9 kbd pulse width", w, PLEN);
    // R11 no second pulse
    for (int i = 0; i < 5; i++) do_tick();
    width(1'b1, w);
    check("R11 no second pulse", w, 0);
    // R8 sticky through ticks and nonzero write
    check("R8 flag held", int'(expired), 1);
    wr(8'h71, 8'h10);
    check("R8 nonzero write keeps flag", int'(expired), 1);
    wr(8'h71, 8'h00);
    check("R8 zero write clears flag", int'(expired), 0);

    // R9 power-OK pulse only
    setup(8'h90, 4'h0, 16'd1);
    do_tick();
    check("R9 pwrok expiry", int'(expired), 1);
    check("R9 kbd disabled", int'(kbd_rst), 0);
    width(1'b0, w);
    check("R9 pwrok pulse width", w, PLEN);

    // R7 force through control write
    setup(8'hC0, 4'h0, 16'd50);
    wr(8'h71, 8'h02);
    check("R7 ctrl force sets flag", int'(expired), 1);
    rd(8'h71, d);
    check("R7 force bit reads zero", int'(d & 8'h02), 0);
    wr(8'h71, 8'h00);
    for (int i = 0; i < 60; i++) do_tick();
    check("R7 counter stopped after force", int'(expired), 0);

    // R7 force through input
    setup(8'h80, 4'h0, 16'd50);
    @(negedge clk); force_req = 1'b1;
    @(negedge clk); force_req = 1'b0;
    check("R7 force input sets flag", int'(expired), 1);

    summary();
  end
endmodule